// File: doc/BRIEF.md
# Bus Enumeration Walker

This block is a bus master that discovers what sits on an address space by reading self-description tables from it. Software or a reset sequencer gives it the address of the root table and pulses `start`. The walker then fetches 64-byte records one 32-bit word at a time over a single-outstanding read port and checks the header record of each table. It visits every record the header announces and follows bridge records down into the tables of sub-buses, to any depth the return stack allows.

Every device record it meets becomes one entry on an output stream. The entry carries the 64-bit vendor identifier, the 32-bit device identifier and the first and last addresses of the device. These addresses are made absolute by adding the base of every enclosing sub-bus. The run ends with `done` when the root table is finished, or with `err` on a bad header or too much nesting. The flag stays up until the next `start`.

The walker does not look at name strings, dates or version fields.

Top module: `enum_walker`

## Requirements
- R1: After reset the walker is idle: `rd_req`, `ent_valid`, `busy`, `done` and `err` are all low.
- R2: Record i of a table lives at table address + i*64. Its sixteen words are read in rising order at a 4-byte stride. `rd_addr` is held steady from the cycle `rd_req` rises until the cycle `rd_ack` is seen.
- R3: Bus words are big-endian: the byte at the lowest address is `rd_data[31:24]`. The 64-bit vendor identifier is the word at offset 24 (upper half) followed by the word at offset 28 (lower half).
- R4: The record kind is the low byte of the word at offset 60, the last byte of the record. The codes are 0x00 table header, 0x01 device, 0x02 bridge and 0x80 integration.
- R5: A table header must carry kind 0x00 and the magic value MAGIC in the word at offset 0. The low 16 bits of the word at offset 4 give the record count of the table, header included. A bad header raises `err`, and the walker issues no further reads.
- R6: A device record yields one entry. The entry's first address is the space base plus the word at offset 12, its last address is the space base plus the word at offset 20, and its device identifier is the word at offset 32.
- R7: A bridge record opens a child space. The child base is the current base plus the bridge word at offset 12. The child table is at the current base plus the bridge word at offset 36. The walker walks the child table and then resumes the parent at the record after the bridge.
- R8: Integration records and records of any unknown kind are skipped and produce no entry.
- R9: Up to DEPTH nested bridges are followed. A bridge met while DEPTH levels are already open raises `err`.
- R10: An entry is offered with `ent_valid` and held unchanged until `ent_ready`. No bus read is issued while an entry waits.
- R11: `done` rises once the root table is finished, and it never appears together with `err`. `done` and `err` hold until the next `start`. A `start` pulse while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| root_addr | input | 32 | Byte address of the root table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished cleanly (held) |
| err | output | 1 | Walk aborted (held) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 32 | Byte address of the word being read |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 32 | Read data, big-endian byte order |
| ent_valid | output | 1 | Device entry offered |
| ent_ready | input | 1 | Consumer accepts the entry |
| ent_vendor | output | 64 | Vendor identifier |
| ent_device | output | 32 | Device identifier |
| ent_first | output | 32 | Absolute first address |
| ent_last | output | 32 | Absolute last address |

## Verification
The bench builds a three-level tree whose last bridge is the final record of its table. A walker that pops only one level, or resumes at the bridge rather than after it, loses or repeats the root's trailing device. Stacked relative offsets expose a walker that adds only the innermost base or takes child tables as absolute. Bridge chains of exactly DEPTH and DEPTH+1 levels catch an off-by-one in the overflow test, and a skipped integration record placed between two devices catches a walker that emits it or loses its place.

Holding `ent_ready` low shows whether the entry stays frozen and the bus stays silent. A wrong magic shows whether the walk stops after one record. A restart after an aborted walk shows whether stale stack levels are cleared.

// File: rtl/enum_walk_pkg.sv
`timescale 1ns/1ps
package enum_walk_pkg;

  localparam int WORD_W    = 32;
  localparam int AW        = 32;
  localparam int CNT_W     = 16;
  localparam int REC_BYTES = 64;
  localparam int REC_SHIFT = $clog2(REC_BYTES);
  localparam int REC_WORDS = REC_BYTES / (WORD_W / 8);
  localparam int WIDX_W    = $clog2(REC_WORDS);

  // word slots inside a record (byte offset = slot * 4)
  localparam logic [WIDX_W-1:0] W_MAGIC  = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_COUNT  = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_FIRST  = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] W_LAST   = WIDX_W'(5);
  localparam logic [WIDX_W-1:0] W_VEN_HI = WIDX_W'(6);
  localparam logic [WIDX_W-1:0] W_VEN_LO = WIDX_W'(7);
  localparam logic [WIDX_W-1:0] W_DEVID  = WIDX_W'(8);
  localparam logic [WIDX_W-1:0] W_CHILD  = WIDX_W'(9);
  localparam logic [WIDX_W-1:0] W_KIND   = WIDX_W'(REC_WORDS - 1);

  // record kinds
  localparam logic [7:0] K_HDR    = 8'h00;
  localparam logic [7:0] K_DEV    = 8'h01;
  localparam logic [7:0] K_BRIDGE = 8'h02;
  localparam logic [7:0] K_INTEG  = 8'h80;

  typedef struct packed {
    logic [WORD_W-1:0]   magic;
    logic [CNT_W-1:0]    count;
    logic [WORD_W-1:0]   first;
    logic [WORD_W-1:0]   last;
    logic [2*WORD_W-1:0] vendor;
    logic [WORD_W-1:0]   devid;
    logic [WORD_W-1:0]   child;
    logic [7:0]          kind;
  } rec_t;

  typedef struct packed {
    logic [AW-1:0]    tbl;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    base;
  } frame_t;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_NEXT, S_REC, S_EMIT, S_DONE, S_ERR
  } walk_st_t;

endpackage

// File: rtl/enum_rec_fetch.sv
`timescale 1ns/1ps
module enum_rec_fetch
  import enum_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     go_addr,
  output logic              busy,
  output logic              fdone,
  output rec_t              rec,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] rd_data
);

  logic              act_q, act_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [AW-1:0]     rbase_q, rbase_d;
  rec_t              rec_q, rec_d;
  logic              fdone_q, fdone_d;

  always_comb begin
    act_d   = act_q;
    widx_d  = widx_q;
    rbase_d = rbase_q;
    rec_d   = rec_q;
    fdone_d = 1'b0;
    if (!act_q) begin
      if (go) begin
        act_d   = 1'b1;
        widx_d  = '0;
        rbase_d = go_addr;
      end
    end else if (rd_ack) begin
      case (widx_q)
        W_MAGIC:  rec_d.magic               = rd_data;
        W_COUNT:  rec_d.count               = rd_data[CNT_W-1:0];
        W_FIRST:  rec_d.first               = rd_data;
        W_LAST:   rec_d.last                = rd_data;
        W_VEN_HI: rec_d.vendor[2*WORD_W-1:WORD_W] = rd_data;
        W_VEN_LO: rec_d.vendor[WORD_W-1:0]  = rd_data;
        W_DEVID:  rec_d.devid               = rd_data;
        W_CHILD:  rec_d.child               = rd_data;
        W_KIND:   rec_d.kind                = rd_data[7:0];
        default:  ;
      endcase
      if (widx_q == W_KIND) begin
        act_d   = 1'b0;
        fdone_d = 1'b1;
      end else begin
        widx_d = widx_q + WIDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      widx_q  <= '0;
      rbase_q <= '0;
      rec_q   <= '0;
      fdone_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      widx_q  <= widx_d;
      rbase_q <= rbase_d;
      rec_q   <= rec_d;
      fdone_q <= fdone_d;
    end
  end

  assign busy    = act_q;
  assign fdone   = fdone_q;
  assign rec     = rec_q;
  assign rd_req  = act_q;
  assign rd_addr = rbase_q + AW'({widx_q, 2'b00});

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R2
  rd_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack && (rd_addr[5:2] != 4'hF) |=> rd_req && (rd_addr == $past(rd_addr) + AW'(4)));

endmodule

// File: rtl/enum_ret_stack.sv
`timescale 1ns/1ps
module enum_ret_stack
  import enum_walk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   push,
  input  logic   pop,
  input  frame_t din,
  output frame_t top,
  output logic   full,
  output logic   empty
);

  localparam int SP_W = $clog2(DEPTH + 1);

  logic [SP_W-1:0] sp_q, sp_d;
  frame_t          slot_q [DEPTH];

  always_comb begin
    sp_d = sp_q;
    if (clr)               sp_d = '0;
    else if (push && !full) sp_d = sp_q + SP_W'(1);
    else if (pop && !empty) sp_d = sp_q - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           slot_q[g] <= '0;
      else if (push && (sp_q == SP_W'(g)))  slot_q[g] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SP_W'(i + 1)) top = slot_q[i];
    end
  end

  assign full  = (sp_q == SP_W'(DEPTH));
  assign empty = (sp_q == '0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R7
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/enum_walker.sv
`timescale 1ns/1ps
module enum_walker
  import enum_walk_pkg::*;
#(
  parameter int          DEPTH = 4,
  parameter logic [31:0] MAGIC = 32'h5DB0_0C1E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] root_addr,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        ent_valid,
  input  logic        ent_ready,
  output logic [63:0] ent_vendor,
  output logic [31:0] ent_device,
  output logic [31:0] ent_first,
  output logic [31:0] ent_last
);

  walk_st_t         st_q, st_d;
  logic [AW-1:0]    tbl_q, tbl_d, base_q, base_d;
  logic [CNT_W-1:0] idx_q, idx_d, cnt_q, cnt_d;
  logic [63:0]      ven_q, ven_d;
  logic [31:0]      dev_q, dev_d, first_q, first_d, last_q, last_d;

  logic          go, fbusy, fdone;
  logic [AW-1:0] go_addr;
  rec_t          rec;
  logic          push, pop, clr, full, empty;
  frame_t        frame_in, top;

  enum_rec_fetch u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .go_addr (go_addr),
    .busy    (fbusy),
    .fdone   (fdone),
    .rec     (rec),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data)
  );

  enum_ret_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (push),
    .pop   (pop),
    .din   (frame_in),
    .top   (top),
    .full  (full),
    .empty (empty)
  );

  assign frame_in = '{tbl: tbl_q, idx: idx_q, cnt: cnt_q, base: base_q};

  always_comb begin
    st_d    = st_q;
    tbl_d   = tbl_q;
    base_d  = base_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    ven_d   = ven_q;
    dev_d   = dev_q;
    first_d = first_q;
    last_d  = last_q;
    go      = 1'b0;
    go_addr = tbl_q;
    push    = 1'b0;
    pop     = 1'b0;
    clr     = 1'b0;
    case (st_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          clr     = 1'b1;
          go      = 1'b1;
          go_addr = root_addr;
          tbl_d   = root_addr;
          base_d  = '0;
          st_d    = S_HDR;
        end
      end
      S_HDR: begin
        if (fdone) begin
          if ((rec.kind == K_HDR) && (rec.magic == MAGIC)) begin
            cnt_d = rec.count;
            idx_d = CNT_W'(1);
            st_d  = S_NEXT;
          end else begin
            st_d = S_ERR;
          end
        end
      end
      S_NEXT: begin
        if (idx_q >= cnt_q) begin
          if (empty) begin
            st_d = S_DONE;
          end else begin
            pop    = 1'b1;
            tbl_d  = top.tbl;
            idx_d  = top.idx + CNT_W'(1);
            cnt_d  = top.cnt;
            base_d = top.base;
          end
        end else begin
          go      = 1'b1;
          go_addr = tbl_q + (AW'(idx_q) << REC_SHIFT);
          st_d    = S_REC;
        end
      end
      S_REC: begin
        if (fdone) begin
          case (rec.kind)
            K_DEV: begin
              ven_d   = rec.vendor;
              dev_d   = rec.devid;
              first_d = base_q + rec.first;
              last_d  = base_q + rec.last;
              st_d    = S_EMIT;
            end
            K_BRIDGE: begin
              if (full) begin
                st_d = S_ERR;
              end else begin
                push    = 1'b1;
                base_d  = base_q + rec.first;
                tbl_d   = base_q + rec.child;
                go      = 1'b1;
                go_addr = base_q + rec.child;
                st_d    = S_HDR;
              end
            end
            default: begin
              idx_d = idx_q + CNT_W'(1);
              st_d  = S_NEXT;
            end
          endcase
        end
      end
      S_EMIT: begin
        if (ent_ready) begin
          idx_d = idx_q + CNT_W'(1);
          st_d  = S_NEXT;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      tbl_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      ven_q   <= '0;
      dev_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      st_q    <= st_d;
      tbl_q   <= tbl_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      ven_q   <= ven_d;
      dev_q   <= dev_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign busy       = (st_q != S_IDLE) && (st_q != S_DONE) && (st_q != S_ERR);
  assign done       = (st_q == S_DONE);
  assign err        = (st_q == S_ERR);
  assign ent_valid  = (st_q == S_EMIT);
  assign ent_vendor = ven_q;
  assign ent_device = dev_q;
  assign ent_first  = first_q;
  assign ent_last   = last_q;

  // R10
  ent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_vendor) && $stable(ent_device)
                                && $stable(ent_first) && $stable(ent_last));

  // R10
  emit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> !rd_req);

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_req && !ent_valid);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R2
  fetch_idle_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !fbusy);

endmodule

// File: tb/tb_enum_walker.sv
`timescale 1ns/1ps
module tb_enum_walker;

  localparam logic [31:0] MAGIC = 32'h5DB0_0C1E;
  localparam int          MEMW  = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] root_addr;
  logic        busy, done, err;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        ent_valid;
  logic        ent_ready;
  logic [63:0] ent_vendor;
  logic [31:0] ent_device, ent_first, ent_last;

  always #2 clk = ~clk;

  enum_walker #(.DEPTH(4), .MAGIC(MAGIC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .root_addr(root_addr),
    .busy(busy), .done(done), .err(err),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_vendor(ent_vendor),
    .ent_device(ent_device), .ent_first(ent_first), .ent_last(ent_last)
  );

  logic [31:0] mem [MEMW];
  int n_chk = 0, n_fail = 0;
  int n_reads = 0, n_order_bad = 0, n_oob = 0, n_ent = 0;
  logic [31:0] last_rd = '0;
  logic [63:0] cap_ven [64];
  logic [31:0] cap_dev [64], cap_first [64], cap_last [64];

  // memory model: one word answered every other cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else if (rd_req && !rd_ack) begin
      rd_ack  <= 1'b1;
      rd_data <= (rd_addr < 32'(MEMW * 4)) ? mem[rd_addr[12:2]] : 32'hDEAD_BEEF;
    end else begin
      rd_ack <= 1'b0;
    end
  end

  // read log
  always @(posedge clk) begin
    if (rst_n && rd_req && rd_ack) begin
      n_reads <= n_reads + 1;
      if ((rd_addr[5:0] != 6'd0) && (rd_addr != last_rd + 32'd4)) n_order_bad <= n_order_bad + 1;
      if (rd_addr >= 32'(MEMW * 4)) n_oob <= n_oob + 1;
      last_rd <= rd_addr;
    end
  end

  // entry capture
  always @(posedge clk) begin
    if (rst_n && ent_valid && ent_ready && n_ent < 64) begin
      cap_ven[n_ent]   <= ent_vendor;
      cap_dev[n_ent]   <= ent_device;
      cap_first[n_ent] <= ent_first;
      cap_last[n_ent]  <= ent_last;
      n_ent <= n_ent + 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, act=hung exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEMW; i++) mem[i] = 32'h0000_00EE; // kind 0xEE where unset
  endtask

  task automatic put_w(input logic [31:0] a, input logic [31:0] d);
    mem[a[12:2]] = d;
  endtask

  task automatic put_hdr(input logic [31:0] t, input logic [15:0] cnt);
    put_w(t + 0, MAGIC);
    put_w(t + 4, {16'h0, cnt});
    put_w(t + 60, 32'h0000_0000);
  endtask

  task automatic put_dev(input logic [31:0] r, input logic [31:0] f, input logic [31:0] l,
                         input logic [63:0] v, input logic [31:0] d);
    put_w(r + 12, f);
    put_w(r + 20, l);
    put_w(r + 24, v[63:32]);
    put_w(r + 28, v[31:0]);
    put_w(r + 32, d);
    put_w(r + 60, 32'h0000_0001);
  endtask

  task automatic put_bridge(input logic [31:0] r, input logic [31:0] f, input logic [31:0] child);
    put_w(r + 12, f);
    put_w(r + 20, f + 32'hFFF);
    put_w(r + 36, child);
    put_w(r + 60, 32'h0000_0002);
  endtask

  task automatic put_kind(input logic [31:0] r, input logic [7:0] k);
    put_w(r + 12, 32'h0000_7000);
    put_w(r + 20, 32'h0000_7FFF);
    put_w(r + 60, {24'h0, k});
  endtask

  task automatic run_walk(input logic [31:0] root, output bit ended);
    ended = 1'b0;
    @(negedge clk);
    root_addr = root;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done || err) begin
        ended = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(ended, "R11", "walk ended", {63'h0, ended}, 64'h1);
  endtask

  task automatic build_flat(input logic [31:0] t);
    put_hdr(t, 16'd4);
    put_dev(t + 64, 32'h0000_0100, 32'h0000_01FF, 64'h8123_4567_89AB_CDEF, 32'h0000_00A1);
    put_kind(t + 128, 8'h80);
    put_dev(t + 192, 32'h0000_0300, 32'h0000_037F, 64'h8000_0000_0000_0042, 32'h0000_00B2);
  endtask

  task automatic test_reset();
    chk(rd_req == 1'b0, "R1", "rd_req", {63'h0, rd_req}, 64'h0);
    chk(ent_valid == 1'b0, "R1", "ent_valid", {63'h0, ent_valid}, 64'h0);
    chk(busy == 1'b0, "R1", "busy", {63'h0, busy}, 64'h0);
    chk(done == 1'b0, "R1", "done", {63'h0, done}, 64'h0);
    chk(err == 1'b0, "R1", "err", {63'h0, err}, 64'h0);
  endtask

  task automatic test_flat();
    bit ended;
    int r0, e0, o0;
    clear_mem();
    build_flat(32'h0000_0800);
    r0 = n_reads; e0 = n_ent; o0 = n_order_bad;
    run_walk(32'h0000_0800, ended);
    repeat (2) @(negedge clk);
    chk(done && !err, "R11", "flat done", {62'h0, done, err}, 64'h2);
    chk(n_reads - r0 == 64, "R2", "flat word reads", 64'(n_reads - r0), 64'd64);
    chk(n_order_bad == o0, "R2", "flat read order", 64'(n_order_bad - o0), 64'd0);
    chk(n_ent - e0 == 2, "R8", "flat entry count (integration skipped)", 64'(n_ent - e0), 64'd2);
    chk(cap_ven[e0] == 64'h8123_4567_89AB_CDEF, "R3", "vendor word order", cap_ven[e0], 64'h8123_4567_89AB_CDEF);
    chk(cap_dev[e0] == 32'hA1, "R6", "device id", 64'(cap_dev[e0]), 64'hA1);
    chk(cap_first[e0] == 32'h100 && cap_last[e0] == 32'h1FF, "R6", "range 0",
        {cap_first[e0], cap_last[e0]}, {32'h100, 32'h1FF});
    chk(cap_dev[e0+1] == 32'hB2 && cap_ven[e0+1] == 64'h8000_0000_0000_0042, "R4", "second device after integration",
        64'(cap_dev[e0+1]), 64'hB2);
    chk(cap_first[e0+1] == 32'h300 && cap_last[e0+1] == 32'h37F, "R6", "range 1",
        {cap_first[e0+1], cap_last[e0+1]}, {32'h300, 32'h37F});
  endtask

  task automatic test_magic();
    bit ended;
    int r0, e0;
    clear_mem();
    build_flat(32'h0);
    put_w(32'h0, MAGIC ^ 32'h0000_0100);
    r0 = n_reads; e0 = n_ent;
    run_walk(32'h0, ended);
    repeat (6) @(negedge clk);
    chk(err && !done, "R5", "bad magic flags err", {62'h0, done, err}, 64'h1);
    chk(n_reads - r0 == 16, "R5", "no reads past header", 64'(n_reads - r0), 64'd16);
    chk(n_ent == e0, "R5", "no entries", 64'(n_ent - e0), 64'd0);
  endtask

  task automatic test_nested();
    bit ended;
    int r0, e0;
    clear_mem();
    // root at 0x000, space base 0
    put_hdr(32'h000, 16'd4);
    put_dev(32'h040, 32'h0000_1000, 32'h0000_10FF, 64'h8000_0000_0000_0A0A, 32'hD0);
    put_bridge(32'h080, 32'h0000_0400, 32'h0000_0400);
    put_dev(32'h0C0, 32'h0000_3000, 32'h0000_30FF, 64'h8000_0000_0000_0D0D, 32'hD3);
    // child table at 0x400, space base 0x400
    put_hdr(32'h400, 16'd4);
    put_kind(32'h440, 8'h55);
    put_dev(32'h480, 32'h0000_0010, 32'h0000_001F, 64'h8000_0000_0000_0B0B, 32'hD1);
    put_bridge(32'h4C0, 32'h0000_0200, 32'h0000_0100);
    // grandchild table at 0x500, space base 0x600
    put_hdr(32'h500, 16'd2);
    put_dev(32'h540, 32'h0000_0008, 32'h0000_000F, 64'h8000_0000_0000_0C0C, 32'hD2);
    r0 = n_reads; e0 = n_ent;
    run_walk(32'h0, ended);
    repeat (2) @(negedge clk);
    chk(done && !err, "R7", "nested done", {62'h0, done, err}, 64'h2);
    chk(n_ent - e0 == 4, "R8", "nested entry count (unknown kind skipped)", 64'(n_ent - e0), 64'd4);
    chk(n_reads - r0 == 160, "R7", "nested word reads", 64'(n_reads - r0), 64'd160);
    chk(n_oob == 0, "R7", "child table address", 64'(n_oob), 64'd0);
    chk(cap_dev[e0] == 32'hD0 && cap_first[e0] == 32'h1000, "R6", "root dev",
        {cap_dev[e0], cap_first[e0]}, {32'hD0, 32'h1000});
    chk(cap_dev[e0+1] == 32'hD1 && cap_first[e0+1] == 32'h410 && cap_last[e0+1] == 32'h41F, "R7",
        "child dev absolute", {cap_first[e0+1], cap_last[e0+1]}, {32'h410, 32'h41F});
    chk(cap_dev[e0+2] == 32'hD2 && cap_first[e0+2] == 32'h608 && cap_last[e0+2] == 32'h60F, "R7",
        "grandchild dev absolute", {cap_first[e0+2], cap_last[e0+2]}, {32'h608, 32'h60F});
    chk(cap_dev[e0+3] == 32'hD3 && cap_first[e0+3] == 32'h3000, "R7", "root resumed after two pops",
        {cap_dev[e0+3], cap_first[e0+3]}, {32'hD3, 32'h3000});
  endtask

  task automatic build_chain(input int n);
    clear_mem();
    for (int k = 0; k < n; k++) begin
      put_hdr(32'(k * 256), 16'd2);
      put_bridge(32'(k * 256 + 64), 32'h0, 32'((k + 1) * 256));
    end
    put_hdr(32'(n * 256), 16'd1);
  endtask

  task automatic test_depth();
    bit ended;
    build_chain(4);
    run_walk(32'h0, ended);
    repeat (2) @(negedge clk);
    chk(done && !err, "R9", "DEPTH levels accepted", {62'h0, done, err}, 64'h2);
    build_chain(5);
    run_walk(32'h0, ended);
    repeat (2) @(negedge clk);
    chk(err && !done, "R9", "DEPTH+1 levels rejected", {62'h0, done, err}, 64'h1);
  endtask

  task automatic test_backpressure();
    bit seen, ended;
    int r0, e0;
    logic [63:0] v0;
    logic [31:0] f0;
    clear_mem();
    build_flat(32'h0);
    e0 = n_ent;
    ent_ready = 1'b0;
    @(negedge clk);
    root_addr = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (ent_valid) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(seen, "R10", "entry offered", {63'h0, seen}, 64'h1);
    v0 = ent_vendor; f0 = ent_first; r0 = n_reads;
    repeat (12) @(negedge clk);
    chk(ent_valid == 1'b1, "R10", "valid held while stalled", {63'h0, ent_valid}, 64'h1);
    chk(ent_vendor == v0 && ent_first == f0, "R10", "entry stable while stalled", ent_vendor, v0);
    chk(n_reads == r0, "R10", "no reads while stalled", 64'(n_reads - r0), 64'd0);
    ent_ready = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
    ended = done;
    chk(ended && n_ent - e0 == 2, "R10", "walk completes after release", 64'(n_ent - e0), 64'd2);
  endtask

  task automatic test_restart();
    bit ended;
    int e0;
    clear_mem();
    build_flat(32'h0);
    // bad table at 0x400: a start aimed here while busy must be ignored
    put_w(32'h400, 32'h1234_5678);
    put_w(32'h43C, 32'h0);
    e0 = n_ent;
    @(negedge clk);
    root_addr = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    root_addr = 32'h400;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
    chk(done && !err && n_ent - e0 == 2, "R11", "start while busy ignored",
        {62'h0, done, err}, 64'h2);
    repeat (8) @(negedge clk);
    chk(done == 1'b1, "R11", "done held", {63'h0, done}, 64'h1);
    // abort with stale stack levels, then restart cleanly
    build_chain(5);
    run_walk(32'h0, ended);
    chk(err == 1'b1, "R9", "aborted walk", {63'h0, err}, 64'h1);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R11", "err held", {63'h0, err}, 64'h1);
    build_chain(4);
    run_walk(32'h0, ended);
    repeat (2) @(negedge clk);
    chk(done && !err, "R11", "restart after abort clears nesting", {62'h0, done, err}, 64'h2);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    root_addr = '0;
    ent_ready = 1'b1;
    clear_mem();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_flat();
    test_magic();
    test_nested();
    test_depth();
    test_backpressure();
    test_restart();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule